// File: doc/BRIEF.md
# Network Status LED Driver

This block drives a single status LED pin of an Ethernet controller. A 4-bit mode field picks the condition that lights the lamp. The choices cover link speed, link presence, packet activity, collision, duplex, host-bus lane width and transmit pause, plus forced on and forced off. Three more bits shape the result: blink enable, blink rate and pin polarity. The shaped value is registered before it reaches the pin.

The configuration comes out of reset from a packed 16-bit word parameter. Software can rewrite it later through a plain write-enable port that takes the same word layout. Blink timing and event stretching count a one-cycle tick, nominally one per millisecond. Short strobes such as activity and collision are held on for one blink half-period, so even a one-cycle event gives a visible flash.

Top module: `netled_drv`

## Requirements
- R1: Out of reset the configuration equals parameter `RST_CFG` (default 16'h0600: mode 0110, not blinking, active-low pin). With no link the pin is high, and with a 100 Mb/s link it is low.
- R2: Speed modes use `link_speed` encoded as 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s and 11 = no valid speed. Each of these modes requires `link_up`. Mode 0000 lights on 10 or 1000, mode 0001 on 100 or 1000, mode 0010 on any link, and modes 0101, 0110 and 0111 on 10, 100 and 1000 only.
- R3: Mode 1011 lights on link with packet activity. Mode 0011 lights on link with filter-passed activity only. Mode 0100 lights on link with no packet activity.
- R4: Mode 1001 follows `full_duplex`, mode 1010 follows the stretched `collision`, mode 1100 follows `bus_x1`, and mode 1101 follows `tx_paused`.
- R5: Mode 1110 is always lit. Mode 1111 and the reserved mode 1000 are never lit.
- R6: A one-cycle strobe on `rx_tx_pkt`, `rx_tx_filt` or `collision` holds its condition for the current half-period in ticks. The condition ends once that many ticks have passed after the strobe.
- R7: With blink enabled and the source lit, the pin toggles every `SLOW_HALF` ticks when the rate bit is 0, or every `FAST_HALF` ticks when it is 1. With the source unlit, the pin stays inactive.
- R8: A change of the blink-rate bit restarts the half-period with the lamp in its on phase.
- R9: The polarity bit set to 1 gives an active-high pin, and set to 0 gives an active-low pin. The pin changes on the clock edge after its inputs change, never before.
- R10: A write with `cfg_we` high loads word bits 15 (blink), 14 (polarity), 13 (rate) and 11:8 (mode). Bit 12 and bits 7:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle timing tick |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration word |
| link_up | input | 1 | Link established |
| link_speed | input | 2 | Link speed code |
| full_duplex | input | 1 | Full-duplex operation |
| rx_tx_pkt | input | 1 | Packet activity strobe |
| rx_tx_filt | input | 1 | Filter-passed packet strobe |
| collision | input | 1 | Collision strobe |
| bus_x1 | input | 1 | Single-lane host bus detected |
| tx_paused | input | 1 | Transmitter paused by flow control |
| led_pin | output | 1 | LED drive pin |

## Verification
The level-driven part of the mode decoder is swept exhaustively. The sweep covers all sixteen modes and both polarities, crossed with every mix of link, the four speed codes, duplex, lane width and pause, and it shows that each mode keys on its own inputs and on nothing else. Strobe tests send single-cycle activity, filtered activity and collision pulses with the link up and with it down. These tests separate the plain-activity, filtered-activity and idle-link modes and measure the stretch to the exact tick. Blink runs count ticks across both rates after a forced restart. Writes with the reserved and low bits set show that those bits do nothing.

// File: rtl/netled_pkg.sv
package netled_pkg;

   typedef enum logic [3:0] {
      M_LNK_10_1G  = 4'h0,
      M_LNK_100_1G = 4'h1,
      M_LNK_ANY    = 4'h2,
      M_FILT_ACT   = 4'h3,
      M_LNK_IDLE   = 4'h4,
      M_LNK_10     = 4'h5,
      M_LNK_100    = 4'h6,
      M_LNK_1G     = 4'h7,
      M_RSVD       = 4'h8,
      M_FDX        = 4'h9,
      M_COLL       = 4'hA,
      M_ACT        = 4'hB,
      M_X1         = 4'hC,
      M_PAUSE      = 4'hD,
      M_ON         = 4'hE,
      M_OFF        = 4'hF
   } led_mode_e;

   typedef enum logic [1:0] {
      SPD_10   = 2'b00,
      SPD_100  = 2'b01,
      SPD_1G   = 2'b10,
      SPD_NONE = 2'b11
   } led_speed_e;

   typedef struct packed {
      logic      blink;
      logic      pol;
      logic      rate;
      led_mode_e mode;
   } led_cfg_t;

   localparam int BIT_BLINK = 15;
   localparam int BIT_POL   = 14;
   localparam int BIT_RATE  = 13;
   localparam int MODE_LSB  = 8;

   function automatic led_cfg_t unpack_cfg(input logic [15:0] w);
      led_cfg_t c;
      c.blink = w[BIT_BLINK];
      c.pol   = w[BIT_POL];
      c.rate  = w[BIT_RATE];
      c.mode  = led_mode_e'(w[MODE_LSB +: 4]);
      return c;
   endfunction

endpackage

// File: rtl/nl_cfg_reg.sv
module nl_cfg_reg
   import netled_pkg::*;
#(
   parameter logic [15:0] RST_WORD = 16'h0600
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we_i,
   input  logic [15:0] wdata_i,
   output led_cfg_t    cfg_o
);

   localparam led_cfg_t RST_CFG = unpack_cfg(RST_WORD);

   generate
      if (RST_WORD[12] != 1'b0) begin : g_bad_rst_word
         $error("nl_cfg_reg: reserved bit 12 of RST_WORD must be zero");
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{wdata_i[12], wdata_i[7:0]};

   always_ff @(posedge clk) begin
      if (!rst_n)    cfg_o <= RST_CFG;
      else if (we_i) cfg_o <= unpack_cfg(wdata_i);
   end

   p_cfg_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (cfg_o.mode == $past(wdata_i[11:8])) && (cfg_o.pol == $past(wdata_i[14])));

endmodule

// File: rtl/nl_blink.sv
module nl_blink #(
   parameter int          SLOW_HALF = 200,
   parameter int          FAST_HALF = 83,
   parameter logic        RST_RATE  = 1'b0,
   localparam int         MAX_HALF  = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF,
   localparam int         CNT_W     = $clog2(MAX_HALF + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             rate_i,
   output logic             phase_o,
   output logic [CNT_W-1:0] half_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             prev_rate_q;
   logic             rate_chg;

   assign half_o   = rate_i ? CNT_W'(FAST_HALF) : CNT_W'(SLOW_HALF);
   assign rate_chg = (rate_i != prev_rate_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         phase_o     <= 1'b1;
         prev_rate_q <= RST_RATE;
      end else begin
         prev_rate_q <= rate_i;
         if (rate_chg) begin
            cnt_q   <= '0;
            phase_o <= 1'b1;
         end else if (tick_i) begin
            if (cnt_q >= half_o - 1'b1) begin
               cnt_q   <= '0;
               phase_o <= ~phase_o;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rate_chg |=> (phase_o && cnt_q == '0));

   p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !rate_chg) |=> $stable(phase_o));

endmodule

// File: rtl/nl_stretch.sv
module nl_stretch #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] half_i,
   input  logic             strobe_i,
   output logic             hold_o
);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                       left_q <= '0;
      else if (strobe_i)                left_q <= half_i;
      else if (tick_i && left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign hold_o = strobe_i | (left_q != '0);

   p_strobe_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && half_i != '0) |=> hold_o);

endmodule

// File: rtl/nl_src_sel.sv
module nl_src_sel
   import netled_pkg::*;
(
   input  led_mode_e  mode_i,
   input  logic       link_i,
   input  led_speed_e speed_i,
   input  logic       fdx_i,
   input  logic       act_i,
   input  logic       filt_i,
   input  logic       coll_i,
   input  logic       x1_i,
   input  logic       pause_i,
   output logic       lit_o
);

   logic at10, at100, at1g;

   assign at10  = link_i && (speed_i == SPD_10);
   assign at100 = link_i && (speed_i == SPD_100);
   assign at1g  = link_i && (speed_i == SPD_1G);

   always_comb begin
      unique case (mode_i)
         M_LNK_10_1G:  lit_o = at10 | at1g;
         M_LNK_100_1G: lit_o = at100 | at1g;
         M_LNK_ANY:    lit_o = link_i;
         M_FILT_ACT:   lit_o = link_i & filt_i;
         M_LNK_IDLE:   lit_o = link_i & ~act_i;
         M_LNK_10:     lit_o = at10;
         M_LNK_100:    lit_o = at100;
         M_LNK_1G:     lit_o = at1g;
         M_RSVD:       lit_o = 1'b0;
         M_FDX:        lit_o = fdx_i;
         M_COLL:       lit_o = coll_i;
         M_ACT:        lit_o = link_i & act_i;
         M_X1:         lit_o = x1_i;
         M_PAUSE:      lit_o = pause_i;
         M_ON:         lit_o = 1'b1;
         M_OFF:        lit_o = 1'b0;
         default:      lit_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/netled_drv.sv
module netled_drv
   import netled_pkg::*;
#(
   parameter logic [15:0] RST_CFG    = 16'h0600,
   parameter int          SLOW_HALF  = 200,
   parameter int          FAST_HALF  = 83,
   parameter bit          STRETCH_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_1ms,
   input  logic        cfg_we,
   input  logic [15:0] cfg_wdata,
   input  logic        link_up,
   input  logic [1:0]  link_speed,
   input  logic        full_duplex,
   input  logic        rx_tx_pkt,
   input  logic        rx_tx_filt,
   input  logic        collision,
   input  logic        bus_x1,
   input  logic        tx_paused,
   output logic        led_pin
);

   localparam int MAX_HALF = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
   localparam int CNT_W    = $clog2(MAX_HALF + 1);
   localparam int N_EVT    = 3;

   generate
      if (SLOW_HALF < 1 || FAST_HALF < 1) begin : g_bad_half
         $error("netled_drv: half-periods must be at least one tick");
      end
   endgenerate

   led_cfg_t         cfg_q;
   logic             phase;
   logic [CNT_W-1:0] half;
   logic [N_EVT-1:0] evt_raw, evt_held;
   logic             src_lit, shaped;

   nl_cfg_reg #(.RST_WORD(RST_CFG)) i_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .wdata_i(cfg_wdata), .cfg_o(cfg_q)
   );

   nl_blink #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF), .RST_RATE(RST_CFG[BIT_RATE])) i_blink (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_1ms), .rate_i(cfg_q.rate),
      .phase_o(phase), .half_o(half)
   );

   assign evt_raw = {collision, rx_tx_filt, rx_tx_pkt};

   generate
      for (genvar e = 0; e < N_EVT; e++) begin : g_evt
         if (STRETCH_EN) begin : g_str
            nl_stretch #(.CNT_W(CNT_W)) i_str (
               .clk(clk), .rst_n(rst_n), .tick_i(tick_1ms), .half_i(half),
               .strobe_i(evt_raw[e]), .hold_o(evt_held[e])
            );
         end else begin : g_pass
            assign evt_held[e] = evt_raw[e];
         end
      end
   endgenerate

   nl_src_sel i_sel (
      .mode_i(cfg_q.mode), .link_i(link_up), .speed_i(led_speed_e'(link_speed)),
      .fdx_i(full_duplex), .act_i(evt_held[0]), .filt_i(evt_held[1]),
      .coll_i(evt_held[2]), .x1_i(bus_x1), .pause_i(tx_paused), .lit_o(src_lit)
   );

   assign shaped = cfg_q.blink ? (src_lit & phase) : src_lit;

   always_ff @(posedge clk) begin
      if (!rst_n) led_pin <= ~RST_CFG[BIT_POL];
      else        led_pin <= cfg_q.pol ? shaped : ~shaped;
   end

   p_never_lit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_q.mode) == M_OFF || $past(cfg_q.mode) == M_RSVD) |-> (led_pin == ~$past(cfg_q.pol)));

   p_steady_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_q.mode) == M_ON && !$past(cfg_q.blink)) |-> (led_pin == $past(cfg_q.pol)));

   p_blink_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_q.blink) && !$past(phase)) |-> (led_pin == ~$past(cfg_q.pol)));

endmodule

// File: tb/test_netled_drv.sv
module test_netled_drv;

   localparam int SLOW = 4;
   localparam int FAST = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1ms = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        link_up = 1'b0;
   logic [1:0]  link_speed = 2'b11;
   logic        full_duplex = 1'b0;
   logic        rx_tx_pkt = 1'b0;
   logic        rx_tx_filt = 1'b0;
   logic        collision = 1'b0;
   logic        bus_x1 = 1'b0;
   logic        tx_paused = 1'b0;
   logic        led_pin;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   netled_drv #(.RST_CFG(16'h0600), .SLOW_HALF(SLOW), .FAST_HALF(FAST), .STRETCH_EN(1'b1)) i_netled_drv (
      .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .link_up(link_up), .link_speed(link_speed), .full_duplex(full_duplex),
      .rx_tx_pkt(rx_tx_pkt), .rx_tx_filt(rx_tx_filt), .collision(collision),
      .bus_x1(bus_x1), .tx_paused(tx_paused), .led_pin(led_pin)
   );

   function automatic logic [15:0] word(input logic bl, input logic pol, input logic rt, input logic [3:0] m);
      return {bl, pol, rt, 1'b0, m, 8'h00};
   endfunction

   function automatic logic exp_lit(input int m, input logic lk, input int sp,
                                    input logic dx, input logic ln, input logic ps);
      case (m)
         0:  return lk && (sp == 0 || sp == 2);
         1:  return lk && (sp == 1 || sp == 2);
         2:  return lk;
         4:  return lk;
         5:  return lk && sp == 0;
         6:  return lk && sp == 1;
         7:  return lk && sp == 2;
         9:  return dx;
         12: return ln;
         13: return ps;
         14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string req, input logic exp);
      n_chk++;
      if (led_pin !== exp) begin
         n_err++;
         $display("FAIL %s: led_pin=%b expected=%b at %0t", req, led_pin, exp, $time);
      end
   endtask

   task automatic wr(input logic [15:0] w);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_we = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_1ms = 1'b1;
         @(negedge clk); tick_1ms = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic pulse_pkt();  @(negedge clk); rx_tx_pkt = 1'b1;  @(negedge clk); rx_tx_pkt = 1'b0;  endtask
   task automatic pulse_filt(); @(negedge clk); rx_tx_filt = 1'b1; @(negedge clk); rx_tx_filt = 1'b0; endtask
   task automatic pulse_coll(); @(negedge clk); collision = 1'b1;  @(negedge clk); collision = 1'b0;  endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state and defaults
      chk("R1 reset pin inactive", 1'b1);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R1 default no link", 1'b1);
      link_up = 1'b1; link_speed = 2'b01;
      @(negedge clk);
      chk("R1 default 100M lit low", 1'b0);
      link_speed = 2'b10;
      @(negedge clk);
      chk("R1 default 1000M not lit", 1'b1);

      // R2 R4 R5 R9: exhaustive sweep of level-driven modes
      for (int m = 0; m < 16; m++)
         for (int p = 0; p < 2; p++)
            for (int lk = 0; lk < 2; lk++)
               for (int sp = 0; sp < 4; sp++)
                  for (int v = 0; v < 8; v++) begin
                     link_up = lk[0]; link_speed = sp[1:0];
                     full_duplex = v[0]; bus_x1 = v[1]; tx_paused = v[2];
                     wr(word(1'b0, p[0], 1'b0, m[3:0]));
                     chk("R2/R4/R5/R9 sweep",
                         p[0] ? exp_lit(m, lk[0], sp, v[0], v[1], v[2])
                              : ~exp_lit(m, lk[0], sp, v[0], v[1], v[2]));
                  end

      full_duplex = 1'b0; bus_x1 = 1'b0; tx_paused = 1'b0;
      link_up = 1'b1; link_speed = 2'b00;

      // R3 R6: activity stretch, active-high, slow half
      wr(word(1'b0, 1'b1, 1'b0, 4'hB));
      chk("R3 act idle off", 1'b0);
      pulse_pkt();
      chk("R6 act stretched start", 1'b1);
      tk(SLOW - 1);
      chk("R6 act held before end", 1'b1);
      tk(1);
      chk("R6 act released after half", 1'b0);

      // R3: idle-link mode darkens during activity
      wr(word(1'b0, 1'b1, 1'b0, 4'h4));
      chk("R3 idle mode lit", 1'b1);
      pulse_pkt();
      chk("R3 idle mode dark on act", 1'b0);
      tk(SLOW);
      chk("R3 idle mode relit", 1'b1);

      // R3: filtered activity mode ignores plain activity
      wr(word(1'b0, 1'b1, 1'b0, 4'h3));
      pulse_pkt();
      chk("R3 filt mode ignores pkt", 1'b0);
      tk(SLOW);
      pulse_filt();
      chk("R3 filt mode lit", 1'b1);
      tk(SLOW);
      chk("R3 filt mode released", 1'b0);

      // R3: activity needs link
      link_up = 1'b0;
      wr(word(1'b0, 1'b1, 1'b0, 4'hB));
      pulse_pkt();
      chk("R3 act without link", 1'b0);
      tk(SLOW);
      link_up = 1'b1;

      // R4 R6: collision with fast half-period
      wr(word(1'b0, 1'b1, 1'b1, 4'hA));
      chk("R4 coll off", 1'b0);
      pulse_coll();
      chk("R4 coll lit", 1'b1);
      tk(FAST - 1);
      chk("R6 coll held fast", 1'b1);
      tk(1);
      chk("R6 coll released fast", 1'b0);

      // R7 R8: blinking, restart on rate change
      wr(word(1'b1, 1'b1, 1'b0, 4'hE));
      chk("R8 restart on phase slow", 1'b1);
      tk(SLOW - 1);
      chk("R7 slow still on", 1'b1);
      tk(1);
      chk("R7 slow toggled off", 1'b0);
      tk(SLOW - 1);
      chk("R7 slow still off", 1'b0);
      tk(1);
      chk("R7 slow back on", 1'b1);
      tk(2);
      wr(word(1'b1, 1'b1, 1'b1, 4'hE));
      chk("R8 restart on phase fast", 1'b1);
      tk(FAST - 1);
      chk("R7 fast still on", 1'b1);
      tk(1);
      chk("R7 fast toggled off", 1'b0);
      tk(FAST);
      chk("R7 fast back on", 1'b1);
      wr(word(1'b1, 1'b0, 1'b1, 4'hF));
      for (int i = 0; i < 2 * FAST; i++) begin
         tk(1);
         chk("R7 blink unlit stays inactive", 1'b1);
      end

      // R9: registered output
      wr(word(1'b0, 1'b1, 1'b0, 4'h2));
      link_up = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R9 no link off", 1'b0);
      link_up = 1'b1;
      #1;
      chk("R9 not before edge", 1'b0);
      @(negedge clk);
      chk("R9 after edge", 1'b1);

      // R10: reserved and low bits ignored
      link_up = 1'b0;
      wr(16'h0600 | 16'h10FE);
      chk("R10 low bits ignored", 1'b1);
      wr(16'h7F00 | 16'h10FF);
      chk("R10 bit12 ignored off", 1'b0);
      wr(16'h5E00 | 16'h10FF);
      chk("R10 bit12 ignored on", 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule